// File: doc/BRIEF.md
# Set-Associative Tag Controller with Selectable Replacement

This block holds the tag and valid state of a set-associative cache and decides, for each lookup, whether the addressed block is resident and which way would be replaced on a miss. Set count, block size, associativity, address width, the replacement rule and the response delay are all parameters. A single-set configuration gives a fully associative structure.

A lookup presents an address and a read/write flag for one cycle. A fixed number of cycles later the block returns hit or miss, the way that matched, a victim way and whether that victim holds a valid line. The surrounding controller fetches the block from the next level. It then hands the address and the chosen way back through the fill port, which installs the tag. A flush pulse drops every line and returns the replacement state to its reset value. Data storage, dirty tracking and write-back belong to other blocks.

Top module: `tagcache_ctrl`

## Requirements
- R1: The address splits from low to high into log2(BLOCK_BYTES) offset bits, log2(SETS) index bits and the remaining tag bits. The offset bits play no part in a lookup or a fill.
- R2: A request accepted in cycle n produces a one-cycle `rsp_valid` pulse in cycle n+HIT_LAT. `rsp_valid` is low in every other cycle.
- R3: `rsp_hit` is 1 exactly when the indexed set holds a valid line whose tag equals the request tag. On a hit, `rsp_hit_way` gives that way.
- R4: When the indexed set has an invalid way, the victim is the lowest-numbered invalid way and `rsp_victim_valid` is 0, whatever the policy. When the set is full, `rsp_victim_valid` is 1.
- R5: With POLICY = LRU and a full set, the victim is the way least recently hit or filled in that set.
- R6: With POLICY = FIFO, each set keeps a pointer that starts at way 0 and advances by one, wrapping after WAYS-1, on every fill to that set. Hits leave it unchanged. With a full set, the victim is the pointer.
- R7: With POLICY = RANDOM and a full set, the victim is a free-running 16-bit LFSR value modulo WAYS, so successive misses on full sets name differing ways.
- R8: A cycle with `fill_valid` high writes the tag of `fill_addr` into way `fill_way` of its set and marks the line valid. A later lookup of that block hits in that way.
- R9: A `flush` pulse invalidates every line and resets all replacement state. After it, the first miss in any set names victim way 0 with `rsp_victim_valid` = 0. Flush takes precedence over a fill in the same cycle.
- R10: A write lookup (`req_write` = 1) gives the same hit, way and victim results and the same replacement update as a read.
- R11: After reset, every line is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines and reset replacement state |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | Lookup is a write (same handling as a read) |
| req_addr | input | ADDR_W | Lookup byte address |
| fill_valid | input | 1 | Install a block |
| fill_addr | input | ADDR_W | Byte address of the block being installed |
| fill_way | input | WAY_W | Way that receives the block |
| rsp_valid | output | 1 | Response strobe, HIT_LAT cycles after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | WAY_W | Matching way on a hit |
| rsp_victim_way | output | WAY_W | Way to replace |
| rsp_victim_valid | output | 1 | Victim way currently holds a valid line |

## Verification
The hardest state to reach is a full set in which the replacement policies disagree. Getting there needs every way of one set filled, then hits that reorder recency, then one more miss. The bench builds this once by hand in one set. It then drives long random runs that draw tags from a pool only slightly larger than the associativity and spread them over a few sets, so eviction on full sets occurs again and again. Three instances with different policies and latencies see the same requests, and each is compared with its own reference model of tags, age ranks and pointers. The random-policy instance is held to invalid-first order and to victim variety.

// File: rtl/tagcache_pkg.sv
package tagcache_pkg;
   typedef enum logic [1:0] {
      REPL_LRU  = 2'd0,
      REPL_FIFO = 2'd1,
      REPL_RAND = 2'd2
   } repl_policy_e;

   localparam logic [15:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/tc_lookup.sv
module tc_lookup #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
   input  logic [WAYS-1:0]            valid_row,
   input  logic [TAG_W-1:0]           tag_in,
   input  logic [WAY_W-1:0]           pol_victim,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic [WAYS-1:0]            hit_vec,
   output logic [WAY_W-1:0]           victim_way,
   output logic                       victim_valid
);
   logic [WAY_W-1:0] free_way;
   logic             has_free;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_row[w] && (tag_row[w] == tag_in);
   end

   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w])    hit_way  = WAY_W'(w);
         if (!valid_row[w]) free_way = WAY_W'(w);
      end
   end

   assign hit          = |hit_vec;
   assign has_free     = ~&valid_row;
   assign victim_way   = has_free ? free_way : pol_victim;
   assign victim_valid = !has_free;
endmodule

// File: rtl/tc_repl.sv
module tc_repl
   import tagcache_pkg::*;
#(
   parameter int           SETS   = 16,
   parameter int           WAYS   = 4,
   parameter int           IDX_W  = 4,
   parameter int           WAY_W  = 2,
   parameter repl_policy_e POLICY = REPL_LRU
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [IDX_W-1:0] query_set,
   output logic [WAY_W-1:0] pol_victim
);
   if (POLICY == REPL_LRU) begin : g_lru
      logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
      logic [SETS-1:0]                      upd;
      logic [SETS-1:0][WAY_W-1:0]           upd_way;

      always_comb begin
         for (int s = 0; s < SETS; s++) begin
            upd[s]     = 1'b0;
            upd_way[s] = '0;
            if (fill_en && fill_set == IDX_W'(s)) begin
               upd[s]     = 1'b1;
               upd_way[s] = fill_way;
            end else if (touch_en && touch_set == IDX_W'(s)) begin
               upd[s]     = 1'b1;
               upd_way[s] = touch_way;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end else if (flush) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end else begin
            for (int s = 0; s < SETS; s++) begin
               if (upd[s]) begin
                  for (int w = 0; w < WAYS; w++) begin
                     if (WAY_W'(w) == upd_way[s])
                        age_q[s][w] <= '0;
                     else if (age_q[s][w] < age_q[s][upd_way[s]])
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                  end
               end
            end
         end
      end

      always_comb begin
         pol_victim = '0;
         for (int w = 0; w < WAYS; w++)
            if (age_q[query_set][w] == WAY_W'(WAYS - 1)) pol_victim = WAY_W'(w);
      end
   end else if (POLICY == REPL_FIFO) begin : g_fifo
      logic [SETS-1:0][WAY_W-1:0] ptr_q;
      logic                       unused_touch;
      assign unused_touch = ^{touch_en, touch_set, touch_way, fill_way};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (flush) begin
            ptr_q <= '0;
         end else if (fill_en) begin
            ptr_q[fill_set] <= (ptr_q[fill_set] == WAY_W'(WAYS - 1)) ? '0
                               : ptr_q[fill_set] + 1'b1;
         end
      end
      assign pol_victim = ptr_q[query_set];
   end else begin : g_rand
      logic [15:0] lfsr_q;
      logic        unused_rand;
      assign unused_rand = ^{touch_en, touch_set, touch_way, fill_en, fill_set,
                             fill_way, query_set, flush};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lfsr_q <= 16'h0001;
         else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? LFSR_TAPS : 16'h0000);
      end
      assign pol_victim = WAY_W'(32'(lfsr_q) % WAYS);
   end
endmodule

// File: rtl/tc_delay.sv
module tc_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic [DEPTH-1:0]        v_q;
   logic [DEPTH-1:0][W-1:0] d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q[0] <= in_valid;
         for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      d_q[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
   end

   assign out_valid = v_q[DEPTH-1];
   assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/tagcache_ctrl.sv
module tagcache_ctrl
   import tagcache_pkg::*;
#(
   parameter int           SETS        = 16,
   parameter int           BLOCK_BYTES = 16,
   parameter int           WAYS        = 4,
   parameter int           ADDR_W      = 32,
   parameter repl_policy_e POLICY      = REPL_LRU,
   parameter int           HIT_LAT     = 2,
   localparam int          OFF_W       = $clog2(BLOCK_BYTES),
   localparam int          IDX_BITS    = $clog2(SETS),
   localparam int          IDX_W       = (IDX_BITS > 0) ? IDX_BITS : 1,
   localparam int          WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int          TAG_W       = ADDR_W - OFF_W - IDX_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [WAY_W-1:0]  fill_way,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_hit_way,
   output logic [WAY_W-1:0]  rsp_victim_way,
   output logic              rsp_victim_valid
);
   localparam int PAY_W = 2 + 2 * WAY_W;

   if (SETS < 1 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (BLOCK_BYTES < 1 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLOCK_BYTES must be a power of two");
   end
   if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if (HIT_LAT < 1 || HIT_LAT > 8) begin : g_bad_lat
      $error("HIT_LAT must lie in 1..8");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the geometry");
   end

   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0]            valid_q;

   logic [IDX_W-1:0] req_idx, fill_idx;
   logic [TAG_W-1:0] req_tag, fill_tag;

   if (IDX_BITS == 0) begin : g_one_set
      assign req_idx  = '0;
      assign fill_idx = '0;
   end else begin : g_many_sets
      assign req_idx  = req_addr[OFF_W +: IDX_BITS];
      assign fill_idx = fill_addr[OFF_W +: IDX_BITS];
   end
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

   logic unused_bits;
   assign unused_bits = ^{req_write, req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q <= '0;
      else if (flush)      valid_q <= '0;
      else if (fill_valid) valid_q[fill_idx][fill_way] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_valid && !flush) tag_q[fill_idx][fill_way] <= fill_tag;
   end

   logic [WAYS-1:0]  lk_hit_vec, lk_valid_row;
   logic             lk_hit, lk_victim_valid;
   logic [WAY_W-1:0] lk_hit_way, lk_victim_way, pol_victim;

   assign lk_valid_row = valid_q[req_idx];

   tc_repl #(
      .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .POLICY(POLICY)
   ) repl_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .touch_en(req_valid && lk_hit), .touch_set(req_idx), .touch_way(lk_hit_way),
      .fill_en(fill_valid), .fill_set(fill_idx), .fill_way(fill_way),
      .query_set(req_idx), .pol_victim(pol_victim)
   );

   tc_lookup #(
      .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
   ) look_i (
      .tag_row(tag_q[req_idx]), .valid_row(lk_valid_row), .tag_in(req_tag),
      .pol_victim(pol_victim), .hit(lk_hit), .hit_way(lk_hit_way),
      .hit_vec(lk_hit_vec), .victim_way(lk_victim_way),
      .victim_valid(lk_victim_valid)
   );

   logic [PAY_W-1:0] pay_out;

   tc_delay #(
      .W(PAY_W), .DEPTH(HIT_LAT)
   ) pipe_i (
      .clk(clk), .rst_n(rst_n), .in_valid(req_valid),
      .in_data({lk_hit, lk_hit_way, lk_victim_way, lk_victim_valid}),
      .out_valid(rsp_valid), .out_data(pay_out)
   );

   assign {rsp_hit, rsp_hit_way, rsp_victim_way, rsp_victim_valid} = pay_out;
endmodule

// File: rtl/tagcache_chk.sv
module tagcache_chk #(
   parameter int SETS    = 16,
   parameter int WAYS    = 4,
   parameter int IDX_W   = 4,
   parameter int WAY_W   = 2,
   parameter int HIT_LAT = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 rsp_valid,
   input logic                 flush,
   input logic                 fill_valid,
   input logic [IDX_W-1:0]     fill_idx,
   input logic [WAY_W-1:0]     fill_way,
   input logic [SETS*WAYS-1:0] valid_flat,
   input logic [WAYS-1:0]      hit_vec,
   input logic [WAYS-1:0]      set_valid,
   input logic [WAY_W-1:0]     lk_victim
);
   int unsigned since_rst;
   int unsigned fill_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= 0;
      else if (since_rst < 1000) since_rst <= since_rst + 1;
   end

   assign fill_pos = int'(fill_idx) * WAYS + int'(fill_way);

   a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= HIT_LAT) |-> (rsp_valid == $past(req_valid, HIT_LAT)));

   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(hit_vec));

   a_r4_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(&set_valid)) |-> !set_valid[lk_victim]);

   a_r8_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) |=> valid_flat[$past(fill_pos)]);

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_flat == '0));
endmodule

bind tagcache_ctrl tagcache_chk #(
   .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .HIT_LAT(HIT_LAT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
   .flush(flush), .fill_valid(fill_valid), .fill_idx(fill_idx),
   .fill_way(fill_way), .valid_flat(valid_q), .hit_vec(lk_hit_vec),
   .set_valid(lk_valid_row), .lk_victim(lk_victim_way)
);

// File: tb/tagcache_ctrl_tb_top.sv
module tagcache_ctrl_tb_top;
   import tagcache_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NSETS = 16;
   localparam int NWAYS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] fill_addr = '0;
   logic        fill_v [3];
   logic [1:0]  fill_w [3];
   logic        rv [3];
   logic        rh [3];
   logic [1:0]  rw [3];
   logic [1:0]  rvw [3];
   logic        rvv [3];

   int          lat [3] = '{2, 1, 3};
   int          vectors = 0;
   int          miscompares = 0;
   bit          done = 1'b0;

   int          mtag [3][NSETS][NWAYS];
   bit          mval [3][NSETS][NWAYS];
   int          mage [NSETS][NWAYS];
   int          mptr [NSETS];
   bit          rand_seen [NWAYS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   tagcache_ctrl #(.POLICY(REPL_LRU), .HIT_LAT(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .fill_valid(fill_v[0]),
      .fill_addr(fill_addr), .fill_way(fill_w[0]), .rsp_valid(rv[0]),
      .rsp_hit(rh[0]), .rsp_hit_way(rw[0]), .rsp_victim_way(rvw[0]),
      .rsp_victim_valid(rvv[0]));

   tagcache_ctrl #(.POLICY(REPL_FIFO), .HIT_LAT(1)) dut_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .fill_valid(fill_v[1]),
      .fill_addr(fill_addr), .fill_way(fill_w[1]), .rsp_valid(rv[1]),
      .rsp_hit(rh[1]), .rsp_hit_way(rw[1]), .rsp_victim_way(rvw[1]),
      .rsp_victim_valid(rvv[1]));

   tagcache_ctrl #(.POLICY(REPL_RAND), .HIT_LAT(3)) dut_rand (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .fill_valid(fill_v[2]),
      .fill_addr(fill_addr), .fill_way(fill_w[2]), .rsp_valid(rv[2]),
      .rsp_hit(rh[2]), .rsp_hit_way(rw[2]), .rsp_victim_way(rvw[2]),
      .rsp_victim_valid(rvv[2]));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) mval[p][s][w] = 1'b0;
      for (int s = 0; s < NSETS; s++) begin
         mptr[s] = 0;
         for (int w = 0; w < NWAYS; w++) mage[s][w] = w;
      end
   endtask

   task automatic lru_touch(input int s, input int tw);
      int ref_age = mage[s][tw];
      for (int w = 0; w < NWAYS; w++) begin
         if (w == tw) mage[s][w] = 0;
         else if (mage[s][w] < ref_age) mage[s][w]++;
      end
   endtask

   task automatic predict(input int p, input int s, input int tg, output bit hit,
                          output int hw, output int vw, output bit full);
      hit = 1'b0; hw = 0; vw = -1; full = 1'b1;
      for (int w = NWAYS - 1; w >= 0; w--) begin
         if (mval[p][s][w] && mtag[p][s][w] == tg) begin hit = 1'b1; hw = w; end
         if (!mval[p][s][w]) begin full = 1'b0; vw = w; end
      end
      if (full) begin
         if (p == 0) begin
            for (int w = 0; w < NWAYS; w++) if (mage[s][w] == NWAYS - 1) vw = w;
         end else if (p == 1) begin
            vw = mptr[s];
         end
      end
   endtask

   task automatic check_rsp(input int p, input bit eh, input int ehw, input int ev,
                            input bit ef, input string lab);
      string pn = (p == 0) ? "lru" : (p == 1) ? "fifo" : "rand";
      check(rv[p] == 1'b1, {lab, " R2 rsp_valid at latency ", pn}, rv[p], 1);
      check(rh[p] == eh, {lab, " R3 hit ", pn}, rh[p], eh);
      if (eh) check(rw[p] == ehw[1:0], {lab, " R3 hit way ", pn}, rw[p], ehw);
      check(rvv[p] == ef, {lab, " R4 victim_valid ", pn}, rvv[p], ef);
      if (!ef)
         check(rvw[p] == ev[1:0], {lab, " R4 invalid-first victim ", pn}, rvw[p], ev);
      else if (p == 0)
         check(rvw[p] == ev[1:0], {lab, " R5 LRU victim"}, rvw[p], ev);
      else if (p == 1)
         check(rvw[p] == ev[1:0], {lab, " R6 FIFO victim"}, rvw[p], ev);
      else
         rand_seen[rvw[p]] = 1'b1;
   endtask

   // fill_mode: 0 never, 1 always on miss, 2 on miss with probability 3/4
   task automatic do_access(input logic [31:0] a, input bit wr, input int fill_mode,
                            input string lab);
      int  s = int'(a[7:4]);
      int  tg = int'(a[31:8]);
      bit  eh [3];
      int  ehw [3];
      int  ev [3];
      bit  ef [3];
      bit  dofill;
      for (int p = 0; p < 3; p++) predict(p, s, tg, eh[p], ehw[p], ev[p], ef[p]);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      if (eh[0]) lru_touch(s, ehw[0]);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check_rsp(1, eh[1], ehw[1], ev[1], ef[1], lab);
      check(rv[0] == 1'b0, {lab, " R2 lru not early"}, rv[0], 0);
      @(negedge clk);
      check_rsp(0, eh[0], ehw[0], ev[0], ef[0], lab);
      check(rv[1] == 1'b0, {lab, " R2 fifo one-cycle pulse"}, rv[1], 0);
      @(negedge clk);
      check_rsp(2, eh[2], ehw[2], ev[2], ef[2], lab);
      ev[2] = int'(rvw[2]);
      dofill = (fill_mode == 1) || (fill_mode == 2 && ($urandom % 4) != 0);
      if (dofill && !(eh[0] && eh[1] && eh[2])) begin
         fill_addr = a;
         for (int p = 0; p < 3; p++) begin
            fill_v[p] = !eh[p];
            fill_w[p] = ev[p][1:0];
         end
         @(negedge clk);
         for (int p = 0; p < 3; p++) begin
            fill_v[p] = 1'b0;
            if (!eh[p]) begin
               mtag[p][s][ev[p]] = tg;
               mval[p][s][ev[p]] = 1'b1;
               if (p == 0) lru_touch(s, ev[p]);
               if (p == 1) mptr[s] = (mptr[s] + 1) % NWAYS;
            end
         end
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      model_reset();
   endtask

   function automatic logic [31:0] mk_addr(input int tg, input int s, input int off);
      return {tg[23:0], s[3:0], off[3:0]};
   endfunction

   initial begin
      for (int p = 0; p < 3; p++) begin fill_v[p] = 1'b0; fill_w[p] = '0; end
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: quiet outputs after reset
      for (int p = 0; p < 3; p++)
         check(rv[p] == 1'b0, "R11 rsp_valid low after reset", rv[p], 0);
      // R11/R4: first lookup misses on an empty cache, victim way 0
      do_access(mk_addr(1, 2, 0), 1'b0, 1, "R11 first access");
      // R1: a different offset in the same block hits
      do_access(mk_addr(1, 2, 9), 1'b0, 0, "R1 offset ignored / R8 fill hit");
      do_access(mk_addr(1, 3, 0), 1'b0, 0, "R1 neighbour index misses");
      do_access(mk_addr(2, 2, 5), 1'b0, 1, "R4 second way");
      // Fill set 0 completely, then reorder recency and force an eviction
      for (int t = 10; t < 14; t++) do_access(mk_addr(t, 0, 0), 1'b0, 1, "R8 fill set 0");
      do_access(mk_addr(10, 0, 3), 1'b0, 0, "R5 recency hit");
      do_access(mk_addr(14, 0, 0), 1'b0, 1, "R5 R6 R7 full-set eviction");
      do_access(mk_addr(15, 0, 0), 1'b0, 1, "R6 pointer advance");
      // R10: write lookups give the same outcome as reads
      do_access(mk_addr(11, 0, 0), 1'b1, 1, "R10 write lookup");
      do_access(mk_addr(14, 0, 0), 1'b1, 1, "R10 write hit");
      // R9: flush empties everything and resets replacement state
      do_flush();
      do_access(mk_addr(14, 0, 0), 1'b0, 1, "R9 after flush");
      do_access(mk_addr(1, 2, 0), 1'b0, 0, "R9 other set empty");
      // Random phase: narrow tag pool over few sets to exercise eviction
      for (int i = 0; i < 800; i++) begin
         if (i % 200 == 199) do_flush();
         do_access(mk_addr(int'($urandom % 6), int'($urandom % 3), int'($urandom % 16)),
                   1'(($urandom % 3) == 0), 2, "random");
      end
      begin
         int distinct = 0;
         for (int w = 0; w < NWAYS; w++) if (rand_seen[w]) distinct++;
         check(distinct >= 2, "R7 random victims vary", distinct, 2);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule